// File: doc/BRIEF.md
# Interleaved Memory Line Fill Controller

This block fetches one four-word cache line from a main memory that is split into four banks, with consecutive word addresses placed in different banks. A fill request carries the byte address of the line. The controller broadcasts the line row to the banks, lets their 25-cycle accesses run, and returns the four 32-bit words on a one-word bus, one per cycle, lowest word first. A compile-time parameter selects a serial baseline instead, in which each word gets its own address, access and transfer phases before the next word starts.

The request side is a valid/ready handshake. The controller can hold only one fill at a time, so `req_ready` falls for the whole fill and is the only back-pressure it applies. The return side is a plain strobe bus: `rd_valid` marks each beat and cannot be stalled, so the consumer must take every beat in the cycle it appears. `done` marks the last beat. The bank storage is a behavioural array inside each bank. At reset it is filled with a pattern that can be computed from the word address.

Top module: `lfc_line_fill`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy`, `rd_valid` and `done` are 0 and `req_ready` is 1.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. From the next cycle through the cycle of the last beat, `busy` is 1 and `req_ready` is 0. `req_valid` during that time is ignored and starts no further fill.
- R3: In interleaved mode (`INTERLEAVE`=1), with the acceptance edge counted as edge 0, the four beats occupy cycles 27, 28, 29 and 30 after it. That is 1 address cycle, 25 access cycles and then 4 transfer cycles. `busy` lasts exactly 30 cycles.
- R4: In serial mode (`INTERLEAVE`=0), each word costs 1+25+1 cycles. The beats fall in cycles 27, 54, 81 and 108 after acceptance, and `busy` lasts exactly 108 cycles.
- R5: Beats carry `rd_idx` 0, 1, 2, 3 in that order. Byte address bits [3:2] select the bank and bits [ADDR_W-1:4] select the row. Beat k returns the word at word address w = {row, k}, whose value is {~w, w} with w zero-extended to 16 bits.
- R6: `done` is 1 only in the cycle of the beat with `rd_idx` = 3, exactly once per fill.
- R7: Bits [3:0] of `req_addr` have no effect on the returned words.
- R8: A synchronous reset during a fill ends it. No further beat appears, and `req_ready` is 1 in the cycle after the reset edge.
- R9: A new request can be accepted in the first cycle after the last beat, so back-to-back fills have no idle gap beyond that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fill request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W | Byte address of the line |
| busy | output | 1 | Fill in progress |
| rd_valid | output | 1 | Returned word present this cycle |
| rd_data | output | 32 | Returned word |
| rd_idx | output | 2 | Position of the word within the line |
| done | output | 1 | Last beat of the fill |

## Verification
An internal fault shows up as a beat in the wrong cycle, a word from the wrong bank or row, or a wrong `busy`/`req_ready` level. Each of these is visible in the very cycle it occurs, because the reference predicts every output on every clock. A bank latency counter that is off by one moves the first beat by a cycle. A row latch that follows the bus during a fill returns words from the row of an ignored request. Stale ready flags in serial mode would produce early beats. All three appear within one fill of at most 108 cycles.

// File: rtl/lfc_pkg.sv
package lfc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACCESS
  } fill_state_t;

  // Content of a word in bank storage, derived from its word address.
  function automatic logic [31:0] word_pattern(input logic [15:0] waddr);
    return {~waddr, waddr};
  endfunction

endpackage

// File: rtl/lfc_bank.sv
module lfc_bank #(
  parameter int ROW_W   = 6,
  parameter int LAT     = 25,
  parameter int BANK_ID = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic [ROW_W-1:0] row,
  input  logic             take,
  output logic [31:0]      dout,
  output logic             ok
);
  localparam int ROWS = 1 << ROW_W;
  localparam int CW   = $clog2(LAT + 1);

  logic [31:0]      mem [ROWS];
  logic [CW-1:0]    cnt;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      ok    <= 1'b0;
      dout  <= '0;
      row_q <= '0;
      for (int r = 0; r < ROWS; r++)
        mem[r] <= lfc_pkg::word_pattern(16'({ROW_W'(r), 2'(BANK_ID)}));
    end else if (launch) begin
      cnt   <= CW'(LAT);
      ok    <= 1'b0;
      row_q <= row;
    end else begin
      if (take) ok <= 1'b0;
      if (cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          ok   <= 1'b1;
          dout <= mem[row_q];
        end
      end
    end
  end

  AST_BANK_LAUNCH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    launch |=> (!ok && cnt == CW'(LAT)));                      // R3
  AST_BANK_TAKE_WHEN_OK: assert property (@(posedge clk) disable iff (rst)
    take |-> ok);                                              // R5

endmodule

// File: rtl/lfc_seq.sv
module lfc_seq #(
  parameter int NB         = 4,
  parameter bit INTERLEAVE = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [NB-1:0]         bank_ok,
  output logic                  req_ready,
  output logic                  busy,
  output logic [NB-1:0]         launch,
  output logic [NB-1:0]         take,
  output logic [$clog2(NB)-1:0] beat,
  output logic                  rd_valid,
  output logic                  done
);
  import lfc_pkg::*;
  localparam int BW = $clog2(NB);
  localparam logic [BW-1:0] LAST = BW'(NB - 1);

  fill_state_t state;

  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign rd_valid  = (state == ST_ACCESS) && bank_ok[beat];
  assign take      = rd_valid ? (NB'(1) << beat) : '0;
  assign done      = rd_valid && (beat == LAST);

  generate
    if (INTERLEAVE) begin : g_par
      assign launch = (state == ST_ADDR) ? '1 : '0;
    end else begin : g_ser
      assign launch = (state == ST_ADDR) ? (NB'(1) << beat) : '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      beat  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          state <= ST_ADDR;
          beat  <= '0;
        end
        ST_ADDR: state <= ST_ACCESS;
        ST_ACCESS: if (rd_valid) begin
          if (beat == LAST) begin
            state <= ST_IDLE;
          end else begin
            beat  <= beat + 1'b1;
            state <= INTERLEAVE ? ST_ACCESS : ST_ADDR;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ACCEPT_THEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (busy && !req_ready));        // R2
  AST_DONE_ENDS_FILL: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);                                           // R6
  AST_ONE_TAKE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(take));                                           // R5
  AST_NO_LAUNCH_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (launch == '0));                                 // R2

  generate
    if (INTERLEAVE) begin : g_chk_par
      AST_BEATS_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && beat != '0) |-> $past(rd_valid));         // R3
    end else begin : g_chk_ser
      AST_BEATS_SPACED: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);                               // R4
    end
  endgenerate

endmodule

// File: rtl/lfc_line_fill.sv
module lfc_line_fill #(
  parameter int ADDR_W     = 10,
  parameter int LAT        = 25,
  parameter bit INTERLEAVE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic [1:0]        rd_idx,
  output logic              done
);
  localparam int NB    = 4;
  localparam int SEL_W = $clog2(NB);
  localparam int LOW_W = SEL_W + 2;
  localparam int ROW_W = ADDR_W - LOW_W;

  logic [ROW_W-1:0] row_q;
  logic [NB-1:0]    bank_ok, launch, take;
  logic [31:0]      bank_dout [NB];
  logic [SEL_W-1:0] beat;
  logic             unused_low;

  assign unused_low = ^req_addr[LOW_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)                         row_q <= '0;
    else if (req_valid && req_ready) row_q <= req_addr[ADDR_W-1:LOW_W];
  end

  lfc_seq #(.NB(NB), .INTERLEAVE(INTERLEAVE)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .bank_ok(bank_ok),
    .req_ready(req_ready), .busy(busy), .launch(launch), .take(take),
    .beat(beat), .rd_valid(rd_valid), .done(done)
  );

  generate
    for (genvar b = 0; b < NB; b++) begin : g_bank
      lfc_bank #(.ROW_W(ROW_W), .LAT(LAT), .BANK_ID(b)) u_bank (
        .clk(clk), .rst(rst), .launch(launch[b]), .row(row_q),
        .take(take[b]), .dout(bank_dout[b]), .ok(bank_ok[b])
      );
    end
  endgenerate

  assign rd_data = bank_dout[beat];
  assign rd_idx  = 2'(beat);

  AST_ROW_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(row_q));                 // R7
  AST_DONE_IS_LAST: assert property (@(posedge clk) disable iff (rst)
    done |-> (rd_valid && rd_idx == 2'd3));                    // R6

endmodule

// File: tb/lfc_line_fill_test.sv
module lfc_line_fill_test;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          rv [2];
  logic [AW-1:0] ra [2];
  logic          rdy [2], bsy [2], vld [2], dn [2];
  logic [31:0]   dat [2];
  logic [1:0]    idx [2];

  lfc_line_fill #(.ADDR_W(AW), .INTERLEAVE(1'b1)) uut (
    .clk(clk), .rst(rst), .req_valid(rv[0]), .req_ready(rdy[0]),
    .req_addr(ra[0]), .busy(bsy[0]), .rd_valid(vld[0]), .rd_data(dat[0]),
    .rd_idx(idx[0]), .done(dn[0]));

  lfc_line_fill #(.ADDR_W(AW), .INTERLEAVE(1'b0)) uut_serial (
    .clk(clk), .rst(rst), .req_valid(rv[1]), .req_ready(rdy[1]),
    .req_addr(ra[1]), .busy(bsy[1]), .rd_valid(vld[1]), .rd_data(dat[1]),
    .rd_idx(idx[1]), .done(dn[1]));

  int vectors = 0, errors = 0, cyc = 0;
  bit reported = 0;
  string phase = "R1";

  int            active [2];
  int            k [2];
  logic [AW-1:0] aq [2];
  int            beats_seen [2];

  function automatic int limit(input int m);
    return (m == 0) ? 30 : 108;
  endfunction

  task automatic chk(input string tag, input int m, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [phase %s] cyc %0d inst %0d %s: actual %h expected %h",
               tag, phase, cyc, m, what, act, exp);
    end
  endtask

  task automatic compare();
    for (int m = 0; m < 2; m++) begin
      logic ev; int ei; logic [15:0] w;
      ev = 1'b0; ei = 0;
      if (active[m] != 0) begin
        if (m == 0 && k[m] >= 27) begin ev = 1'b1; ei = k[m] - 27; end
        if (m == 1 && (k[m] % 27) == 0) begin ev = 1'b1; ei = k[m] / 27 - 1; end
      end
      chk(rst ? "R1" : "R2", m, "busy", 32'(bsy[m]), 32'(active[m] != 0));
      chk(rst ? "R1" : "R2", m, "req_ready", 32'(rdy[m]), 32'(active[m] == 0));
      chk(m == 0 ? "R3" : "R4", m, "rd_valid", 32'(vld[m]), 32'(ev));
      chk("R6", m, "done", 32'(dn[m]), 32'(ev && ei == 3));
      if (ev) begin
        w = 16'((aq[m] >> 4) * 4 + ei);
        chk("R5", m, "rd_idx", 32'(idx[m]), 32'(ei));
        chk("R5", m, "rd_data", dat[m], {~w, w});
        beats_seen[m]++;
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    cyc++;
    for (int m = 0; m < 2; m++) begin
      if (rst) active[m] = 0;
      else if (active[m] != 0) begin
        if (k[m] == limit(m)) active[m] = 0;
        else k[m]++;
      end else if (rv[m]) begin
        active[m] = 1; k[m] = 1; aq[m] = ra[m];
      end
    end
    @(negedge clk);
    compare();
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      rv[m] = 0; ra[m] = '0; active[m] = 0; k[m] = 0; aq[m] = '0; beats_seen[m] = 0;
    end
    // R1: reset state
    phase = "R1";
    @(negedge clk);
    repeat (3) tick();
    rst = 0;
    tick();

    // R3 / R2 / R9: interleaved fill; req_valid stays high with a new address
    phase = "R9";
    rv[0] = 1; ra[0] = 10'h040;
    tick();
    ra[0] = 10'h2C0;
    repeat (31) tick();
    rv[0] = 0;
    repeat (32) tick();

    // R7: low address bits set, top row
    phase = "R7";
    rv[0] = 1; ra[0] = 10'h3FF;
    tick();
    rv[0] = 0;
    repeat (32) tick();

    // R8: reset in the middle of a fill, after two beats
    phase = "R8";
    rv[0] = 1; ra[0] = 10'h1A5;
    tick();
    rv[0] = 0;
    repeat (27) tick();
    rst = 1;
    tick();
    rst = 0;
    repeat (35) tick();

    // R4: serial baseline, two fills
    phase = "R4";
    rv[1] = 1; ra[1] = 10'h120;
    tick();
    rv[1] = 0;
    repeat (112) tick();
    rv[1] = 1; ra[1] = 10'h3F7;
    tick();
    rv[1] = 0;
    repeat (112) tick();

    // R6: beat totals (4+4+4+2 interleaved, 4+4 serial)
    phase = "R6";
    chk("R6", 0, "beat total", 32'(beats_seen[0]), 32'd14);
    chk("R6", 1, "beat total", 32'(beats_seen[1]), 32'd8);
    report();
  end

endmodule